// File: doc/BRIEF.md
# Fault Capture and Attention Classification Register Bank

This block collects error pulses from one hardware unit into a sticky 64-bit fault capture register. Each captured bit is kept until software clears it. A mask register can hide any bit. Two action registers then give every visible bit one of three attention classes: checkstop, recoverable or host attention. A fourth encoding marks a bit as a local-only event that raises nothing.

Software reaches all of the storage through a single-cycle register access port, addressed by word offset. The capture register can be cleared with an atomic AND write or loaded with a direct write. The mask can be loaded directly, cleared with an AND write, or set with an OR write, so that firmware never needs a read-modify-write sequence. Three registered summary lines report whether any visible bit of each class is set.

Top module: `fault_capture_bank`

## Requirements
- R1: After reset the capture register reads 0, the mask reads all ones, both action registers read 0, and all three summary outputs are 0.
- R2: A 1 on any bit of `err_in` at a clock edge sets that capture bit, and the bit stays set after `err_in` returns to 0.
- R3: A write to offset 1 ANDs `acc_wdata` into the capture register, so every bit written as 0 is cleared. A write to offset 2 loads `acc_wdata` into the capture register. The capture register is read at offset 0.
- R4: When an error pulse and a software clear or load of the same capture bit fall in the same cycle, the bit ends up set.
- R5: The mask is read at offset 3. A write to offset 3 loads the mask, a write to offset 4 ANDs data into it, and a write to offset 5 ORs data into it.
- R6: Action register 0 is written and read at offset 6, and action register 1 at offset 7.
- R7: A set, unmasked capture bit whose action 0 bit is 0 and action 1 bit is 0 drives `chk_o` high.
- R8: A set, unmasked capture bit whose action 0 bit is 0 and action 1 bit is 1 drives `rec_o` high.
- R9: A set, unmasked capture bit whose action 0 bit is 1 and action 1 bit is 0 drives `host_o` high.
- R10: A capture bit whose action bits are both 1, or whose mask bit is 1, drives no summary output.
- R11: Reads at offsets 1, 2, 4 and 5 return 0, and a write to offset 0 changes no register.
- R12: Each summary output changes exactly one clock edge after the register change that causes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| err_in | input | 64 | Error pulses from the unit, one per capture bit |
| acc_wr | input | 1 | Write strobe for the access port, one cycle per write |
| acc_addr | input | 3 | Word offset of the access |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data for `acc_addr`, combinational |
| chk_o | output | 1 | Checkstop summary |
| rec_o | output | 1 | Recoverable summary |
| host_o | output | 1 | Host attention summary |

## Verification
The classification is exercised with a table of mask, action and error patterns. Single bits with each of the four action codes show that each code reaches its own output and no other. Masked bits and the all-ones action code are kept apart from a real lack of errors. Multi-bit patterns that spread over the top and bottom bit positions, with mixed classes, show that each bit is decoded on its own and that several classes can be raised at once. Directed sequences then separate the atomic AND and OR writes from direct loads, show that a pulse wins over a same-cycle clear, and show that the summary changes on the second edge after a write rather than the first.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_CAP_RD   = 3'd0,
        OFS_CAP_AND  = 3'd1,
        OFS_CAP_LOAD = 3'd2,
        OFS_MSK      = 3'd3,
        OFS_MSK_AND  = 3'd4,
        OFS_MSK_OR   = 3'd5,
        OFS_ACTA     = 3'd6,
        OFS_ACTB     = 3'd7
    } ofs_e;

    typedef enum logic [1:0] {
        CLS_CHECKSTOP = 2'b00,
        CLS_RECOVER   = 2'b01,
        CLS_HOST      = 2'b10,
        CLS_LOCAL     = 2'b11
    } cls_e;
endpackage

// File: rtl/fcb_regfile.sv
module fcb_regfile
    import fcb_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        err_in,
    input  logic                acc_wr,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [W-1:0]        acc_wdata,
    output logic [W-1:0]        acc_rdata,
    output logic [W-1:0]        cap_q,
    output logic [W-1:0]        msk_q,
    output logic [W-1:0]        acta_q,
    output logic [W-1:0]        actb_q
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ALL_ZERO = {W{1'b0}};

    ofs_e           ofs;
    logic [W-1:0]   cap_d;
    logic [W-1:0]   msk_d;
    logic [W-1:0]   acta_d;
    logic [W-1:0]   actb_d;
    logic           cap_sw_hit;

    assign ofs = ofs_e'(acc_addr);
    assign cap_sw_hit = acc_wr && (ofs == OFS_CAP_AND || ofs == OFS_CAP_LOAD);

    always_comb begin
        cap_d  = cap_q;
        msk_d  = msk_q;
        acta_d = acta_q;
        actb_d = actb_q;
        if (acc_wr) begin
            unique case (ofs)
                OFS_CAP_RD:   ;
                OFS_CAP_AND:  cap_d  = cap_q & acc_wdata;
                OFS_CAP_LOAD: cap_d  = acc_wdata;
                OFS_MSK:      msk_d  = acc_wdata;
                OFS_MSK_AND:  msk_d  = msk_q & acc_wdata;
                OFS_MSK_OR:   msk_d  = msk_q | acc_wdata;
                OFS_ACTA:     acta_d = acc_wdata;
                OFS_ACTB:     actb_d = acc_wdata;
                default:      ;
            endcase
        end
        cap_d = cap_d | err_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q  <= ALL_ZERO;
            msk_q  <= ALL_ONES;
            acta_q <= ALL_ZERO;
            actb_q <= ALL_ZERO;
        end else begin
            cap_q  <= cap_d;
            msk_q  <= msk_d;
            acta_q <= acta_d;
            actb_q <= actb_d;
        end
    end

    always_comb begin
        unique case (ofs)
            OFS_CAP_RD: acc_rdata = cap_q;
            OFS_MSK:    acc_rdata = msk_q;
            OFS_ACTA:   acc_rdata = acta_q;
            OFS_ACTB:   acc_rdata = actb_q;
            default:    acc_rdata = ALL_ZERO;
        endcase
    end

    AST_CAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cap_sw_hit) |-> ((cap_q & $past(cap_q)) == $past(cap_q))); // R2

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((cap_q & $past(err_in)) == $past(err_in))); // R4

    AST_UNDEF_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr == 3'd1 || acc_addr == 3'd2 || acc_addr == 3'd4 || acc_addr == 3'd5)
        |-> (acc_rdata == ALL_ZERO)); // R11
endmodule

// File: rtl/fcb_classify.sv
module fcb_classify
    import fcb_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    cap_q,
    input  logic [W-1:0]    msk_q,
    input  logic [W-1:0]    acta_q,
    input  logic [W-1:0]    actb_q,
    output logic            chk_o,
    output logic            rec_o,
    output logic            host_o
);
    logic [W-1:0] chk_v;
    logic [W-1:0] rec_v;
    logic [W-1:0] host_v;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic live;
        cls_e cls;
        assign live = cap_q[i] & ~msk_q[i];
        assign cls  = cls_e'({acta_q[i], actb_q[i]});
        always_comb begin
            chk_v[i]  = 1'b0;
            rec_v[i]  = 1'b0;
            host_v[i] = 1'b0;
            unique case (cls)
                CLS_CHECKSTOP: chk_v[i]  = live;
                CLS_RECOVER:   rec_v[i]  = live;
                CLS_HOST:      host_v[i] = live;
                CLS_LOCAL:     ;
                default:       ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_o  <= 1'b0;
            rec_o  <= 1'b0;
            host_o <= 1'b0;
        end else begin
            chk_o  <= |chk_v;
            rec_o  <= |rec_v;
            host_o <= |host_v;
        end
    end

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&$past(msk_q)) |-> !(chk_o || rec_o || host_o)); // R10

    AST_CLEAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cap_q) == '0) |-> !(chk_o || rec_o || host_o)); // R12

    AST_LOCAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(acta_q) & $past(actb_q)) == {W{1'b1}}) |-> !(chk_o || rec_o || host_o)); // R10
endmodule

// File: rtl/fault_capture_bank.sv
module fault_capture_bank
    import fcb_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        err_in,
    input  logic                acc_wr,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [W-1:0]        acc_wdata,
    output logic [W-1:0]        acc_rdata,
    output logic                chk_o,
    output logic                rec_o,
    output logic                host_o
);
    logic [W-1:0] cap_q;
    logic [W-1:0] msk_q;
    logic [W-1:0] acta_q;
    logic [W-1:0] actb_q;

    fcb_regfile #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_in    (err_in),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .cap_q     (cap_q),
        .msk_q     (msk_q),
        .acta_q    (acta_q),
        .actb_q    (actb_q)
    );

    fcb_classify #(.W(W)) u_cls (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_q  (cap_q),
        .msk_q  (msk_q),
        .acta_q (acta_q),
        .actb_q (actb_q),
        .chk_o  (chk_o),
        .rec_o  (rec_o),
        .host_o (host_o)
    );
endmodule

// File: tb/sim_fault_capture_bank.sv
module sim_fault_capture_bank;
    localparam int unsigned W = 64;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] msk;
        logic [W-1:0] acta;
        logic [W-1:0] actb;
        logic [W-1:0] err;
        logic [2:0]   exp;   // {chk, rec, host}
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{msk: 64'h0, acta: 64'h0, actb: 64'h0, err: 64'h1, exp: 3'b100},
        '{msk: 64'h0, acta: 64'h0, actb: 64'h20, err: 64'h20, exp: 3'b010},
        '{msk: 64'h0, acta: 64'h200, actb: 64'h0, err: 64'h200, exp: 3'b001},
        '{msk: 64'h0, acta: 64'h1000, actb: 64'h1000, err: 64'h1000, exp: 3'b000},
        '{msk: 64'h100000, acta: 64'h0, actb: 64'h0, err: 64'h100000, exp: 3'b000},
        '{msk: 64'h0, acta: 64'h0, actb: 64'h8000000000000000, err: 64'h8000000000000002, exp: 3'b110},
        '{msk: 64'h0, acta: 64'h0004000000000000, actb: 64'h0000010000000000, err: 64'h0004010000000004, exp: 3'b111},
        '{msk: 64'hFFFFFFFFFFFFFFFF, acta: 64'h0, actb: 64'h0, err: 64'hFFFFFFFFFFFFFFFF, exp: 3'b000}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [W-1:0]   err_in = '0;
    logic           acc_wr = 1'b0;
    logic [2:0]     acc_addr = 3'd0;
    logic [W-1:0]   acc_wdata = '0;
    logic [W-1:0]   acc_rdata;
    logic           chk_o, rec_o, host_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fault_capture_bank #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .err_in(err_in), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .chk_o(chk_o), .rec_o(rec_o), .host_o(host_o)
    );

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        @(negedge clk);
        acc_addr = a;
        #1 d = acc_rdata;
    endtask

    task automatic pulse(input logic [W-1:0] e);
        @(negedge clk);
        err_in = e;
        @(negedge clk);
        err_in = '0;
    endtask

    function automatic logic [W-1:0] outs();
        return {{(W-3){1'b0}}, chk_o, rec_o, host_o};
    endfunction

    initial begin
        logic [W-1:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, r); check("R1 capture", r, '0);
        rd(3'd3, r); check("R1 mask", r, ONES);
        rd(3'd6, r); check("R1 act0", r, '0);
        rd(3'd7, r); check("R1 act1", r, '0);
        check("R1 outputs", outs(), '0);

        // Table walk: R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            wr(3'd3, VEC[i].msk);
            wr(3'd6, VEC[i].acta);
            wr(3'd7, VEC[i].actb);
            wr(3'd2, '0);
            pulse(VEC[i].err);
            @(negedge clk);
            check($sformatf("R7/R8/R9/R10 vector %0d", i), outs(), {{(W-3){1'b0}}, VEC[i].exp});
        end

        // R6 action registers read back
        rd(3'd6, r); check("R6 act0 readback", r, '0);
        wr(3'd7, 64'hA5A5_0000_1234_FFFF);
        rd(3'd7, r); check("R6 act1 readback", r, 64'hA5A5_0000_1234_FFFF);
        wr(3'd7, '0);

        // R2 sticky
        wr(3'd3, '0);
        wr(3'd2, '0);
        pulse(64'h0000_00F0_0000_0081);
        repeat (3) @(negedge clk);
        rd(3'd0, r); check("R2 sticky", r, 64'h0000_00F0_0000_0081);

        // R3 AND clear and direct load
        wr(3'd1, 64'hFFFF_FF0F_FFFF_FFFE);
        rd(3'd0, r); check("R3 and-clear", r, 64'h0000_0000_0000_0080);
        wr(3'd2, 64'h1111_2222_3333_4444);
        rd(3'd0, r); check("R3 load", r, 64'h1111_2222_3333_4444);

        // R4 set wins over same-cycle clear
        @(negedge clk);
        acc_wr = 1'b1; acc_addr = 3'd1; acc_wdata = '0; err_in = 64'h8;
        @(negedge clk);
        acc_wr = 1'b0; err_in = '0;
        rd(3'd0, r); check("R4 set wins", r, 64'h8);

        // R5 mask writes
        wr(3'd3, 64'h00FF_00FF_00FF_00FF);
        rd(3'd3, r); check("R5 mask load", r, 64'h00FF_00FF_00FF_00FF);
        wr(3'd4, 64'h0F0F_0F0F_0F0F_0F0F);
        rd(3'd3, r); check("R5 mask and", r, 64'h000F_000F_000F_000F);
        wr(3'd5, 64'hF000_0000_0000_0100);
        rd(3'd3, r); check("R5 mask or", r, 64'hF00F_000F_000F_010F);

        // R11 undefined reads and ignored write
        rd(3'd1, r); check("R11 read ofs1", r, '0);
        rd(3'd2, r); check("R11 read ofs2", r, '0);
        rd(3'd4, r); check("R11 read ofs4", r, '0);
        rd(3'd5, r); check("R11 read ofs5", r, '0);
        wr(3'd0, '0);
        rd(3'd0, r); check("R11 write ofs0 ignored", r, 64'h8);

        // R12 latency: capture bit 3 unmasked, class checkstop
        wr(3'd3, ONES);
        @(negedge clk);
        check("R12 masked quiet", outs(), '0);
        wr(3'd4, ~64'h8);
        check("R12 no change first edge", outs(), '0);
        @(negedge clk);
        check("R12 change second edge", outs(), 64'h4);
        wr(3'd1, '0);
        check("R12 hold first edge", outs(), 64'h4);
        @(negedge clk);
        check("R12 drop second edge", outs(), '0);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule